// File: doc/BRIEF.md
# Event-Driven APB Write Generator

This block turns single-cycle event strobes from three sources into APB write transfers aimed at one slave. Every source keeps its own pending tally. While the bus is free, the block picks one source whose tally is non-zero. It then runs a complete write to the fixed address of that source. The write data is the number of strobes that source produced since its last write was launched.

The three sources enter on one vector, `evt_i`. Bit 0 is source A, bit 1 is source B and bit 2 is source C. At most one bit is high in any cycle. The environment keeps each source to no more than ten pending strobes. The slave always raises `pready_i` within ten cycles of the access phase and never reports an error. All state resets through an active-high asynchronous `rst`, and all bus outputs come straight from flip-flops.

Top module: `ev2apb_bridge`

## Requirements
- R1: While `rst` is high and after it is released with no pending strobes, `psel_o` and `penable_o` are low.
- R2: `pwrite_o` is high in every cycle in which `psel_o` is high.
- R3: Writes for source A (`evt_i[0]`) go to 0xABBA0000, for source B (`evt_i[1]`) to 0xBAFF0000 and for source C (`evt_i[2]`) to 0xCAFE0000.
- R4: Each transfer starts with one setup cycle (`psel_o`=1, `penable_o`=0). It is followed on the next cycle by the access phase (`psel_o`=1, `penable_o`=1). `penable_o` is never high without `psel_o`.
- R5: During the access phase, the transfer stays in access while `pready_i` is low. `paddr_o` and `pwdata_o` hold their setup values until completion.
- R6: `pwdata_o` carries the source's strobe count since its previous write was launched, zero-extended to 32 bits.
- R7: After a transfer completes (access phase with `pready_i` high), `psel_o` is low for at least one cycle before the next setup.
- R8: When several sources are pending at the moment the bus becomes free, A is served before B and B before C.
- R9: A strobe that arrives in the cycle its source's count is captured for a write is not lost. It is carried in that source's next write.
- R10: With no strobes, the bus stays idle and no transfer starts.
- R11: A count of ten pending strobes is carried exactly in the write data, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| evt_i | input | 3 | Event strobes: bit 0 = A, bit 1 = B, bit 2 = C |
| pready_i | input | 1 | Slave completion for the access phase |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB enable (access phase) |
| pwrite_o | output | 1 | APB direction, always write during a transfer |
| paddr_o | output | 32 | APB address |
| pwdata_o | output | 32 | APB write data (pending count) |

## Verification
A strobe sampled at clock edge k raises the source's count after edge k. If the bus is idle, the setup phase appears after edge k+1 and the access phase after edge k+2. A transfer completes at the first edge with `pready_i` high in access, and `psel_o` is low for the cycle after that edge. The bench drives strobes and samples the bus on falling edges, so every value it checks has settled half a period after the edge that produced it. Cycle-to-cycle rules (setup to access, hold while waiting, idle gap) are checked against the previous falling-edge sample. Write contents and ordering are checked from a log of completed transfers once the bus has gone quiet.

// File: rtl/ev2apb_pkg.sv
package ev2apb_pkg;

  localparam int unsigned DEF_NUM_SRC  = 3;
  localparam int unsigned DEF_CNT_W    = 4;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_MAX_PEND = 10;

  // Index 0 occupies the low word: source A, then B, then C.
  localparam logic [DEF_NUM_SRC*DEF_ADDR_W-1:0] DEF_BASE_ADDRS =
    {32'hCAFE_0000, 32'hBAFF_0000, 32'hABBA_0000};

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_SETUP  = 2'd1,
    BUS_ACCESS = 2'd2
  } bus_state_e;

endpackage

// File: rtl/ev2apb_src_counter.sv
module ev2apb_src_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // When the count is taken for a write, restart it from this cycle's strobe.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take_i) begin
      cnt_q <= evt_i ? CNT_W'(1) : '0;
    end else if (evt_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ev2apb_prio_pick.sv
module ev2apb_prio_pick #(
  parameter int unsigned N     = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest index wins: walk from the top so the last hit is the lowest.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ev2apb_apb_master.sv
module ev2apb_apb_master
  import ev2apb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pready_i,
  output logic              take_o,
  output logic              psel_o,
  output logic              penable_o,
  output logic              pwrite_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pwdata_o
);

  bus_state_e        state_q;
  logic              psel_q;
  logic              penable_q;
  logic              pwrite_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pwdata_q;

  // A new transfer may only be launched from idle, which also gives the gap.
  assign take_o = (state_q == BUS_IDLE) && req_i;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q   <= BUS_IDLE;
      psel_q    <= 1'b0;
      penable_q <= 1'b0;
      pwrite_q  <= 1'b0;
      paddr_q   <= '0;
      pwdata_q  <= '0;
    end else begin
      case (state_q)
        BUS_IDLE: begin
          if (req_i) begin
            state_q  <= BUS_SETUP;
            psel_q   <= 1'b1;
            pwrite_q <= 1'b1;
            paddr_q  <= addr_i;
            pwdata_q <= data_i;
          end
        end
        BUS_SETUP: begin
          state_q   <= BUS_ACCESS;
          penable_q <= 1'b1;
        end
        BUS_ACCESS: begin
          if (pready_i) begin
            state_q   <= BUS_IDLE;
            psel_q    <= 1'b0;
            penable_q <= 1'b0;
            pwrite_q  <= 1'b0;
          end
        end
        default: begin
          state_q   <= BUS_IDLE;
          psel_q    <= 1'b0;
          penable_q <= 1'b0;
          pwrite_q  <= 1'b0;
        end
      endcase
    end
  end

  assign psel_o    = psel_q;
  assign penable_o = penable_q;
  assign pwrite_o  = pwrite_q;
  assign paddr_o   = paddr_q;
  assign pwdata_o  = pwdata_q;

endmodule

// File: rtl/ev2apb_bridge.sv
module ev2apb_bridge
  import ev2apb_pkg::*;
#(
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned MAX_PEND = DEF_MAX_PEND,
  parameter logic [NUM_SRC*ADDR_W-1:0] BASE_ADDRS = DEF_BASE_ADDRS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               pready_i,
  output logic               psel_o,
  output logic               penable_o,
  output logic               pwrite_o,
  output logic [ADDR_W-1:0]  paddr_o,
  output logic [DATA_W-1:0]  pwdata_o
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [CNT_W-1:0]         cnt_arr [NUM_SRC];
  logic [NUM_SRC*CNT_W-1:0] cnt_flat;
  logic [NUM_SRC-1:0]       pend;
  logic [NUM_SRC-1:0]       take_vec;
  logic                     any_pend;
  logic [IDX_W-1:0]         sel_idx;
  logic                     take;
  logic [ADDR_W-1:0]        sel_addr;
  logic [DATA_W-1:0]        sel_data;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign take_vec[g] = take && (sel_idx == IDX_W'(g));

    ev2apb_src_counter #(
      .CNT_W (CNT_W)
    ) cnt_i (
      .clk    (clk),
      .rst    (rst),
      .evt_i  (evt_i[g]),
      .take_i (take_vec[g]),
      .cnt_o  (cnt_arr[g])
    );

    assign pend[g]                     = (cnt_arr[g] != '0);
    assign cnt_flat[g*CNT_W +: CNT_W]  = cnt_arr[g];
  end

  ev2apb_prio_pick #(
    .N (NUM_SRC)
  ) pick_i (
    .req_i (pend),
    .any_o (any_pend),
    .idx_o (sel_idx)
  );

  assign sel_addr = BASE_ADDRS[sel_idx*ADDR_W +: ADDR_W];
  assign sel_data = DATA_W'(cnt_arr[sel_idx]);

  ev2apb_apb_master #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) bus_i (
    .clk       (clk),
    .rst       (rst),
    .req_i     (any_pend),
    .addr_i    (sel_addr),
    .data_i    (sel_data),
    .pready_i  (pready_i),
    .take_o    (take),
    .psel_o    (psel_o),
    .penable_o (penable_o),
    .pwrite_o  (pwrite_o),
    .paddr_o   (paddr_o),
    .pwdata_o  (pwdata_o)
  );

endmodule

// File: rtl/ev2apb_bridge_chk.sv
module ev2apb_bridge_chk #(
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MAX_PEND = 10,
  parameter logic [NUM_SRC*ADDR_W-1:0] BASE_ADDRS = '0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     pready_i,
  input logic                     psel_o,
  input logic                     penable_o,
  input logic                     pwrite_o,
  input logic [ADDR_W-1:0]        paddr_o,
  input logic [DATA_W-1:0]        pwdata_o,
  input logic [NUM_SRC*CNT_W-1:0] cnt_flat
);

  function automatic logic addr_known(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (BASE_ADDRS[i*ADDR_W +: ADDR_W] == a) hit = 1'b1;
    end
    return hit;
  endfunction

  p_quiet_reset_r1: assert property (@(posedge clk)
    rst |=> (!psel_o && !penable_o));

  p_write_only_r2: assert property (@(posedge clk) disable iff (rst)
    psel_o |-> pwrite_o);

  p_addr_map_r3: assert property (@(posedge clk) disable iff (rst)
    psel_o |-> addr_known(paddr_o));

  p_setup_then_access_r4: assert property (@(posedge clk) disable iff (rst)
    (psel_o && !penable_o) |=> (psel_o && penable_o));

  p_enable_needs_sel_r4: assert property (@(posedge clk) disable iff (rst)
    penable_o |-> psel_o);

  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (psel_o && penable_o && !pready_i) |=>
      (psel_o && penable_o && $stable(paddr_o) && $stable(pwdata_o)));

  p_gap_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    (psel_o && penable_o && pready_i) |=> !psel_o);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ovf
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[g*CNT_W +: CNT_W] <= CNT_W'(MAX_PEND));
  end

  // Write data is a count, never wider than the counter (R6).
  p_data_width_r6: assert property (@(posedge clk) disable iff (rst)
    psel_o |-> (pwdata_o <= DATA_W'(MAX_PEND)));

endmodule

bind ev2apb_bridge ev2apb_bridge_chk #(
  .NUM_SRC    (NUM_SRC),
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .MAX_PEND   (MAX_PEND),
  .BASE_ADDRS (BASE_ADDRS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pready_i  (pready_i),
  .psel_o    (psel_o),
  .penable_o (penable_o),
  .pwrite_o  (pwrite_o),
  .paddr_o   (paddr_o),
  .pwdata_o  (pwdata_o),
  .cnt_flat  (cnt_flat)
);

// File: tb/ev2apb_bridge_tb.sv
module ev2apb_bridge_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  localparam logic [31:0] ADDR_A = 32'hABBA_0000;
  localparam logic [31:0] ADDR_B = 32'hBAFF_0000;
  localparam logic [31:0] ADDR_C = 32'hCAFE_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  evt;
  logic        pready;
  logic        psel, penable, pwrite;
  logic [31:0] paddr, pwdata;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          wait_cfg = 0;
  logic [7:0]  wcnt;
  int          cyc = 0;

  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  int          log_n = 0;

  logic        prev_done, prev_setup, prev_wait;
  logic [31:0] prev_addr, prev_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ev2apb_bridge dut_i (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .pready_i  (pready),
    .psel_o    (psel),
    .penable_o (penable),
    .pwrite_o  (pwrite),
    .paddr_o   (paddr),
    .pwdata_o  (pwdata)
  );

  // Slave model: completes after wait_cfg cycles of access phase.
  assign pready = psel && penable && (int'(wcnt) >= wait_cfg);

  always @(posedge clk) begin
    if (rst || !(psel && penable)) wcnt <= 8'd0;
    else if (!pready) wcnt <= wcnt + 8'd1;
  end

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // Bus monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (rst) begin
      prev_done  <= 1'b0;
      prev_setup <= 1'b0;
      prev_wait  <= 1'b0;
    end else begin
      if (psel && penable && pready) begin
        check(pwrite, "R2 pwrite high on write", 32'(pwrite), 32'd1);
        if (log_n < 16) begin
          log_addr[log_n] = paddr;
          log_data[log_n] = pwdata;
        end
        log_n++;
      end
      if (prev_done) check(!psel, "R7 idle gap after completion", 32'(psel), 32'd0);
      if (prev_setup) check(psel && penable, "R4 setup then access",
                            {30'd0, psel, penable}, 32'd3);
      if (prev_wait) begin
        check(psel && penable, "R5 stays in access while waiting",
              {30'd0, psel, penable}, 32'd3);
        check(paddr == prev_addr, "R5 paddr stable", paddr, prev_addr);
        check(pwdata == prev_data, "R5 pwdata stable", pwdata, prev_data);
      end
      prev_done  <= psel && penable && pready;
      prev_setup <= psel && !penable;
      prev_wait  <= psel && penable && !pready;
      prev_addr  <= paddr;
      prev_data  <= pwdata;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
    end
  end

  // Hold source src high for n consecutive cycles (n strobes).
  task automatic strobe(input int src, input int n);
    @(negedge clk);
    evt[src] = 1'b1;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_entry(input int i, input logic [31:0] a,
                              input logic [31:0] d, input string tag);
    check(log_addr[i] == a, {tag, " address"}, log_addr[i], a);
    check(log_data[i] == d, {tag, " data"}, log_data[i], d);
  endtask

  task automatic t_reset_idle();
    check(!psel && !penable, "R1 bus low after reset", {30'd0, psel, penable}, 32'd0);
    log_n = 0;
    repeat (20) @(negedge clk);
    check(log_n == 0, "R10 no transfer without strobes", 32'(log_n), 32'd0);
    check(!psel, "R10 psel idle", 32'(psel), 32'd0);
  endtask

  task automatic t_each_address();
    wait_cfg = 1;
    log_n = 0;
    strobe(0, 1); settle();
    strobe(1, 1); settle();
    strobe(2, 1); settle();
    check(log_n == 3, "R3 three writes", 32'(log_n), 32'd3);
    expect_entry(0, ADDR_A, 32'd1, "R3 R6 source A");
    expect_entry(1, ADDR_B, 32'd1, "R3 R6 source B");
    expect_entry(2, ADDR_C, 32'd1, "R3 R6 source C");
  endtask

  task automatic t_capture_overlap();
    // Three strobes in a row: first is captured, the one in the capture
    // cycle plus the next go to the following write.
    wait_cfg = 0;
    log_n = 0;
    strobe(0, 3); settle();
    check(log_n == 2, "R9 two writes", 32'(log_n), 32'd2);
    expect_entry(0, ADDR_A, 32'd1, "R9 first write");
    expect_entry(1, ADDR_A, 32'd2, "R9 second write");
  endtask

  task automatic t_priority();
    wait_cfg = 5;
    log_n = 0;
    strobe(2, 1);
    strobe(1, 1);
    strobe(0, 1);
    settle();
    check(log_n == 3, "R8 three writes", 32'(log_n), 32'd3);
    expect_entry(0, ADDR_C, 32'd1, "R8 first C");
    expect_entry(1, ADDR_A, 32'd1, "R8 then A");
    expect_entry(2, ADDR_B, 32'd1, "R8 then B");
  endtask

  task automatic t_max_count();
    wait_cfg = 10;
    log_n = 0;
    strobe(0, 1);
    strobe(1, 10);
    settle();
    check(log_n == 2, "R11 two writes", 32'(log_n), 32'd2);
    expect_entry(0, ADDR_A, 32'd1, "R11 busy write");
    expect_entry(1, ADDR_B, 32'd10, "R11 ten pending");
  endtask

  initial begin
    rst = 1'b1;
    evt = '0;
    repeat (3) @(negedge clk);
    check(!psel && !penable, "R1 bus low in reset", {30'd0, psel, penable}, 32'd0);
    rst = 1'b0;
    t_reset_idle();
    t_each_address();
    t_capture_overlap();
    t_priority();
    t_max_count();
    summary();
  end

endmodule